// File: doc/BRIEF.md
# Accumulator ALU and Instruction Decoder

This block is the arithmetic datapath of a small 8-bit accumulator core with 14-bit instruction words. It is purely combinational. Each cycle the core presents the fetched instruction word, the working register W, the byte read from the register file at the instruction's address, and the current carry flag. The block returns the byte to be written back, where it goes (W or the register file), and whether any write happens at all. It also returns new carry, half-carry and zero values, each with its own write enable, and a request to skip the next instruction.

Three instruction groups are handled. Byte operations combine W with a register operand. Bit operations clear, set or test one bit of a register. Literal operations combine W with an 8-bit constant taken from the instruction. Jumps, calls, returns and the timer, sleep, watchdog and port-control words are not executed here. The block only marks them as non-ALU so that the sequencer can route them elsewhere.

Top module: `alu_core`

## Requirements
- R1: For a byte operation (instr[13:12] = 01), instr[13:8] is the opcode and instr[7] is the destination bit. A value of 0 selects W (destIsReg = 0) and 1 selects the register file (destIsReg = 1). writeEn is 1 for every byte operation except opcode 010000 with instr[7] = 0.
- R2: Opcode 011011 gives result = (R + W) mod 256, carry = carry out of bit 7, half carry = carry out of bit 3, and Z = (result == 0). All three flag enables are set.
- R3: Opcode 011100 gives result = R + ~W + 1 (that is, R − W). Carry is 1 exactly when no borrow occurs (R ≥ W). Half carry is the carry out of bit 3 of that same sum, and Z is updated. All three flag enables are set.
- R4: Opcode 011001 writes R + 1 and opcode 011101 writes R − 1. Each updates only Z (zWe = 1, cWe = hcWe = 0) and never requests a skip.
- R5: Opcode 011010 writes R + 1 and opcode 011110 writes R − 1. Neither enables any flag. skipReq is 1 exactly when the written result is zero.
- R6: These operations enable only Z, with Z = (result == 0): 010010 (R AND W), 010011 (R OR W), 010100 (R XOR W), 011111 (NOT R) and 011000 (load, result = R).
- R7: Opcode 010111 writes R with its two nibbles exchanged and enables no flag.
- R8: Opcode 010110 rotates right through carry: the old carry goes into bit 7 and bit 0 goes to the new carry. Opcode 010101 rotates left through carry: the old carry goes into bit 0 and bit 7 goes to the new carry. Only cWe is set.
- R9: A bit operation has instr[13:12] = 00, with the kind in instr[11:10], the bit index in instr[9:7] and the register in instr[6:0]. Kind 00 clears and kind 10 sets the indexed bit of R. Both write the register and enable no flag.
- R10: Bit kind 01 requests a skip when the indexed bit of R is 0, and kind 11 requests a skip when it is 1. Neither writes anything nor enables a flag.
- R11: Literal operations take the constant from instr[7:0] and always write W. 111010 loads the constant and enables no flag. 110100 (AND), 110101 (OR) and 110110 (XOR) combine it with W and enable only Z.
- R12: 010001 with instr[7] = 0 writes 0 to the register, and 010000 with instr[7] = 1 writes 0 to W. Both enable only Z, which is set to 1. 010001 with instr[7] = 1 writes W unchanged to the register and enables no flag.
- R13: Every other word is marked nonAlu = 1 with writeEn, skipReq and all flag enables at 0. This covers 010000 with instr[7] = 0, all words with instr[13:12] = 10, 110000 through 110011, and 11xxxx opcodes that are not literal operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 14 | Instruction word being executed |
| wReg | input | 8 | Current working register W |
| regOp | input | 8 | Register-file byte addressed by the instruction |
| carryIn | input | 1 | Current carry flag |
| result | output | 8 | Byte to be written back |
| destIsReg | output | 1 | 1: write to register file, 0: write to W |
| writeEn | output | 1 | A write-back takes place |
| cNew | output | 1 | New carry value |
| cWe | output | 1 | Carry flag write enable |
| hcNew | output | 1 | New half-carry value |
| hcWe | output | 1 | Half-carry write enable |
| zNew | output | 1 | New zero value |
| zWe | output | 1 | Zero flag write enable |
| skipReq | output | 1 | Skip the next instruction |
| nonAlu | output | 1 | Word is not executed by this block |

## Verification
The immediate checks assume that regOp already holds the byte at the addressed register, and they read the flag outputs only where the matching enable is set. The values on cNew, hcNew and zNew are free whenever their enable is low. The checks also assume that all inputs are settled 2-state values, because the block has no clock of its own. The directed stimulus changes the inputs only on the falling edge of the bench clock and samples after a short settle delay. It drives only fully specified instruction words, and it computes every expected value from the operand bytes through plain arithmetic on the encodings given in the requirements.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;
  localparam int DATA_W     = 8;
  localparam int NIB_W      = DATA_W / 2;
  localparam int INSTR_W    = 14;
  localparam int OPC_W      = 6;
  localparam int BIT_IDX_W  = $clog2(DATA_W);
  localparam int SUM_W      = DATA_W + 1;
  localparam int NSUM_W     = NIB_W + 1;
  localparam int OPC_LSB    = INSTR_W - OPC_W;
  localparam int DEST_BIT   = OPC_LSB - 1;
  localparam int BKIND_LSB  = INSTR_W - 4;
  localparam int BIDX_LSB   = BKIND_LSB - BIT_IDX_W;

  typedef enum logic [3:0] {
    OP_PASS_B, OP_PASS_W, OP_ZERO, OP_ADD, OP_SUB, OP_INC, OP_DEC,
    OP_AND, OP_IOR, OP_XOR, OP_COM, OP_SWAP, OP_RRC, OP_RLC,
    OP_BCLR, OP_BSET
  } aluOpE;

  typedef enum logic [1:0] {
    SKIP_NONE, SKIP_ZERO, SKIP_BIT_CLR, SKIP_BIT_SET
  } skipE;

  // strobes from decode to the datapath
  typedef struct packed {
    aluOpE                 op;
    logic                  useLit;
    logic [DATA_W-1:0]     litVal;
    logic [BIT_IDX_W-1:0]  bitIdx;
    skipE                  skip;
  } dpCtlT;

  // write-back and flag enables straight to the ports
  typedef struct packed {
    logic wrEn;
    logic toReg;
    logic cWe;
    logic hcWe;
    logic zWe;
    logic nonAlu;
  } wbCtlT;
endpackage

// File: rtl/alu_core_decode.sv
module alu_core_decode
  import alu_core_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dpCtlT              dpCtl,
  output wbCtlT              wbCtl
);
  logic [OPC_W-1:0] opc;
  logic             tBit;
  logic [1:0]       group;
  logic [1:0]       bitKind;

  assign opc     = instr[INSTR_W-1:OPC_LSB];
  assign tBit    = instr[DEST_BIT];
  assign group   = instr[INSTR_W-1:INSTR_W-2];
  assign bitKind = instr[BKIND_LSB+1:BKIND_LSB];

  always_comb begin
    dpCtl        = '0;
    dpCtl.op     = OP_PASS_B;
    dpCtl.skip   = SKIP_NONE;
    dpCtl.litVal = instr[DATA_W-1:0];
    dpCtl.bitIdx = instr[BIDX_LSB+BIT_IDX_W-1:BIDX_LSB];
    wbCtl        = '0;
    if (group == 2'b00) begin
      wbCtl.toReg = 1'b1;
      case (bitKind)
        2'b00: begin dpCtl.op = OP_BCLR; wbCtl.wrEn = 1'b1; end
        2'b10: begin dpCtl.op = OP_BSET; wbCtl.wrEn = 1'b1; end
        2'b01: dpCtl.skip = SKIP_BIT_CLR;
        default: dpCtl.skip = SKIP_BIT_SET;
      endcase
    end else if (group == 2'b01) begin
      wbCtl.wrEn  = 1'b1;
      wbCtl.toReg = tBit;
      case (opc)
        6'b010000: begin
          if (tBit) begin
            dpCtl.op = OP_ZERO; wbCtl.toReg = 1'b0; wbCtl.zWe = 1'b1;
          end else begin
            wbCtl.wrEn = 1'b0; wbCtl.toReg = 1'b0; wbCtl.nonAlu = 1'b1;
          end
        end
        6'b010001: begin
          wbCtl.toReg = 1'b1;
          if (tBit) dpCtl.op = OP_PASS_W;
          else begin dpCtl.op = OP_ZERO; wbCtl.zWe = 1'b1; end
        end
        6'b010010: begin dpCtl.op = OP_AND;  wbCtl.zWe = 1'b1; end
        6'b010011: begin dpCtl.op = OP_IOR;  wbCtl.zWe = 1'b1; end
        6'b010100: begin dpCtl.op = OP_XOR;  wbCtl.zWe = 1'b1; end
        6'b010101: begin dpCtl.op = OP_RLC;  wbCtl.cWe = 1'b1; end
        6'b010110: begin dpCtl.op = OP_RRC;  wbCtl.cWe = 1'b1; end
        6'b010111: dpCtl.op = OP_SWAP;
        6'b011000: begin dpCtl.op = OP_PASS_B; wbCtl.zWe = 1'b1; end
        6'b011001: begin dpCtl.op = OP_INC;  wbCtl.zWe = 1'b1; end
        6'b011010: begin dpCtl.op = OP_INC;  dpCtl.skip = SKIP_ZERO; end
        6'b011011: begin
          dpCtl.op = OP_ADD;
          wbCtl.cWe = 1'b1; wbCtl.hcWe = 1'b1; wbCtl.zWe = 1'b1;
        end
        6'b011100: begin
          dpCtl.op = OP_SUB;
          wbCtl.cWe = 1'b1; wbCtl.hcWe = 1'b1; wbCtl.zWe = 1'b1;
        end
        6'b011101: begin dpCtl.op = OP_DEC;  wbCtl.zWe = 1'b1; end
        6'b011110: begin dpCtl.op = OP_DEC;  dpCtl.skip = SKIP_ZERO; end
        default:   begin dpCtl.op = OP_COM;  wbCtl.zWe = 1'b1; end
      endcase
    end else begin
      dpCtl.useLit = 1'b1;
      wbCtl.wrEn   = 1'b1;
      case (opc)
        6'b111010: dpCtl.op = OP_PASS_B;
        6'b110100: begin dpCtl.op = OP_AND; wbCtl.zWe = 1'b1; end
        6'b110101: begin dpCtl.op = OP_IOR; wbCtl.zWe = 1'b1; end
        6'b110110: begin dpCtl.op = OP_XOR; wbCtl.zWe = 1'b1; end
        default: begin
          dpCtl.useLit = 1'b0; wbCtl.wrEn = 1'b0; wbCtl.nonAlu = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/alu_core_datapath.sv
module alu_core_datapath
  import alu_core_pkg::*;
(
  input  dpCtlT             dpCtl,
  input  logic [DATA_W-1:0] wReg,
  input  logic [DATA_W-1:0] regOp,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              cNew,
  output logic              hcNew,
  output logic              zNew,
  output logic              skipReq
);
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] addB;
  logic              addCin;
  logic [SUM_W-1:0]  fullSum;
  logic [NSUM_W-1:0] lowSum;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] swapped;
  logic              bitVal;

  assign opB = dpCtl.useLit ? dpCtl.litVal : regOp;

  // one shared adder serves add, subtract, increment and decrement
  always_comb begin
    addB   = wReg;
    addCin = 1'b0;
    case (dpCtl.op)
      OP_SUB: begin addB = ~wReg;    addCin = 1'b1; end
      OP_INC: begin addB = '0;       addCin = 1'b1; end
      OP_DEC: begin addB = '1;       addCin = 1'b0; end
      default: ;
    endcase
  end

  assign fullSum = {1'b0, opB} + {1'b0, addB} + SUM_W'(addCin);
  assign lowSum  = {1'b0, opB[NIB_W-1:0]} + {1'b0, addB[NIB_W-1:0]} + NSUM_W'(addCin);

  assign bitMask = DATA_W'(1) << dpCtl.bitIdx;
  assign bitVal  = |(opB & bitMask);

  for (genvar i = 0; i < DATA_W; i++) begin : g_swap
    assign swapped[i] = opB[(i + NIB_W) % DATA_W];
  end

  always_comb begin
    case (dpCtl.op)
      OP_PASS_W: result = wReg;
      OP_ZERO:   result = '0;
      OP_ADD, OP_SUB, OP_INC, OP_DEC: result = fullSum[DATA_W-1:0];
      OP_AND:    result = opB & wReg;
      OP_IOR:    result = opB | wReg;
      OP_XOR:    result = opB ^ wReg;
      OP_COM:    result = ~opB;
      OP_SWAP:   result = swapped;
      OP_RRC:    result = {carryIn, opB[DATA_W-1:1]};
      OP_RLC:    result = {opB[DATA_W-2:0], carryIn};
      OP_BCLR:   result = opB & ~bitMask;
      OP_BSET:   result = opB | bitMask;
      default:   result = opB;
    endcase
  end

  always_comb begin
    case (dpCtl.op)
      OP_RRC:  cNew = opB[0];
      OP_RLC:  cNew = opB[DATA_W-1];
      default: cNew = fullSum[DATA_W];
    endcase
  end

  assign hcNew = lowSum[NIB_W];
  assign zNew  = (result == '0);

  always_comb begin
    case (dpCtl.skip)
      SKIP_ZERO:    skipReq = (result == '0);
      SKIP_BIT_CLR: skipReq = !bitVal;
      SKIP_BIT_SET: skipReq = bitVal;
      default:      skipReq = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_core_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  wReg,
  input  logic [DATA_W-1:0]  regOp,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  result,
  output logic               destIsReg,
  output logic               writeEn,
  output logic               cNew,
  output logic               cWe,
  output logic               hcNew,
  output logic               hcWe,
  output logic               zNew,
  output logic               zWe,
  output logic               skipReq,
  output logic               nonAlu
);
  dpCtlT dpCtl;
  wbCtlT wbCtl;

  alu_core_decode u_decode (
    .instr (instr),
    .dpCtl (dpCtl),
    .wbCtl (wbCtl)
  );

  alu_core_datapath u_datapath (
    .dpCtl   (dpCtl),
    .wReg    (wReg),
    .regOp   (regOp),
    .carryIn (carryIn),
    .result  (result),
    .cNew    (cNew),
    .hcNew   (hcNew),
    .zNew    (zNew),
    .skipReq (skipReq)
  );

  assign writeEn   = wbCtl.wrEn;
  assign destIsReg = wbCtl.toReg;
  assign cWe       = wbCtl.cWe;
  assign hcWe      = wbCtl.hcWe;
  assign zWe       = wbCtl.zWe;
  assign nonAlu    = wbCtl.nonAlu;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk (
  input logic [13:0] instr,
  input logic [7:0]  wReg,
  input logic [7:0]  regOp,
  input logic        carryIn,
  input logic [7:0]  result,
  input logic        destIsReg,
  input logic        writeEn,
  input logic        cNew,
  input logic        cWe,
  input logic        hcNew,
  input logic        hcWe,
  input logic        zNew,
  input logic        zWe,
  input logic        skipReq,
  input logic        nonAlu
);
  logic [5:0] opc;
  logic [8:0] addRef;
  logic [4:0] nibRef;
  assign opc    = instr[13:8];
  assign addRef = {1'b0, regOp} + {1'b0, wReg};
  assign nibRef = {1'b0, regOp[3:0]} + {1'b0, wReg[3:0]};

  always_comb begin
    if (opc == 6'b011011)
      AST_ADD_SUM: assert ({cNew, result} == addRef && hcNew == nibRef[4]); // R2
    if (opc == 6'b011100)
      AST_SUB_NO_BORROW: assert (cNew == (regOp >= wReg) && result == regOp - wReg); // R3
    if (zWe)
      AST_ZERO_FLAG: assert (zNew == (result == 8'h00)); // R4
    if (skipReq)
      AST_SKIP_NO_FLAGS: assert (!cWe && !hcWe && !zWe); // R5
    if (opc == 6'b010110)
      AST_RRC_CARRY: assert (result[7] == carryIn && cNew == regOp[0]); // R8
    if (instr[13:12] == 2'b00)
      AST_BITOP_NO_FLAGS: assert (!cWe && !hcWe && !zWe && destIsReg); // R9
    if (opc == 6'b111010 || opc == 6'b110100 || opc == 6'b110101 || opc == 6'b110110)
      AST_LIT_TO_W: assert (writeEn && !destIsReg); // R11
    if (nonAlu)
      AST_NONALU_QUIET: assert (!writeEn && !skipReq && !cWe && !hcWe && !zWe); // R13
  end
endmodule

bind alu_core alu_core_chk u_chk (.*);

// File: tb/tb_alu_core.sv
module tb_alu_core;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] instr = 14'h1000;
  logic [7:0]  wReg = '0, regOp = '0;
  logic        carryIn = 1'b0;
  logic [7:0]  result;
  logic destIsReg, writeEn, cNew, cWe, hcNew, hcWe, zNew, zWe, skipReq, nonAlu;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core dut (
    .instr(instr), .wReg(wReg), .regOp(regOp), .carryIn(carryIn),
    .result(result), .destIsReg(destIsReg), .writeEn(writeEn),
    .cNew(cNew), .cWe(cWe), .hcNew(hcNew), .hcWe(hcWe),
    .zNew(zNew), .zWe(zWe), .skipReq(skipReq), .nonAlu(nonAlu)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > MAX_CYCLES && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, MAX_CYCLES);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [13:0] enc(logic [5:0] o, logic t, logic [6:0] a);
    return {o, t, a};
  endfunction

  function automatic logic [13:0] encBit(logic [1:0] k, logic [2:0] b, logic [6:0] a);
    return {2'b00, k, b, a};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [13:0] i, logic [7:0] w, logic [7:0] r, logic c);
    @(negedge clk);
    instr = i; wReg = w; regOp = r; carryIn = c;
    #1;
  endtask

  // write-back, enables and skip; result compared only when written
  task automatic expOut(string req, logic [7:0] res, logic dst, logic we,
                        logic ce, logic he, logic ze, logic sk);
    chk(req, "writeEn", writeEn, we);
    if (we) begin
      chk(req, "result", result, res);
      chk(req, "destIsReg", destIsReg, dst);
    end
    chk(req, "cWe", cWe, ce);
    chk(req, "hcWe", hcWe, he);
    chk(req, "zWe", zWe, ze);
    chk(req, "skipReq", skipReq, sk);
    chk(req, "nonAlu", nonAlu, 1'b0);
  endtask

  task automatic testIdle();
    drive(14'h1000, 8'h55, 8'hAA, 1'b0); // R13 no-op word
    chk("R13", "nonAlu", nonAlu, 1);
    chk("R13", "writeEn", writeEn, 0);
    chk("R13", "flagEn", {cWe, hcWe, zWe}, 0);
  endtask

  task automatic testAdd();
    drive(enc(6'b011011, 1'b1, 7'h20), 8'h3A, 8'hC6, 1'b0); // R2 wraps to zero
    expOut("R2", 8'h00, 1, 1, 1, 1, 1, 0);
    chk("R2", "C", cNew, 1); chk("R2", "HC", hcNew, 1); chk("R2", "Z", zNew, 1);
    drive(enc(6'b011011, 1'b0, 7'h21), 8'h01, 8'h02, 1'b1); // R1 dest W
    expOut("R1", 8'h03, 0, 1, 1, 1, 1, 0);
    chk("R2", "C", cNew, 0); chk("R2", "HC", hcNew, 0); chk("R2", "Z", zNew, 0);
  endtask

  task automatic testSub();
    drive(enc(6'b011100, 1'b1, 7'h10), 8'h07, 8'h05, 1'b0); // R3 borrow
    expOut("R3", 8'hFE, 1, 1, 1, 1, 1, 0);
    chk("R3", "C", cNew, 0); chk("R3", "HC", hcNew, 0);
    drive(enc(6'b011100, 1'b0, 7'h10), 8'h01, 8'h10, 1'b0);
    expOut("R3", 8'h0F, 0, 1, 1, 1, 1, 0);
    chk("R3", "C", cNew, 1); chk("R3", "HC", hcNew, 0);
    drive(enc(6'b011100, 1'b1, 7'h10), 8'h33, 8'h33, 1'b0);
    chk("R3", "result", result, 8'h00);
    chk("R3", "C", cNew, 1); chk("R3", "HC", hcNew, 1); chk("R3", "Z", zNew, 1);
  endtask

  task automatic testIncDec();
    drive(enc(6'b011001, 1'b1, 7'h11), 8'h00, 8'hFF, 1'b0); // R4
    expOut("R4", 8'h00, 1, 1, 0, 0, 1, 0);
    chk("R4", "Z", zNew, 1);
    drive(enc(6'b011101, 1'b0, 7'h11), 8'h00, 8'h05, 1'b0);
    expOut("R4", 8'h04, 0, 1, 0, 0, 1, 0);
    chk("R4", "Z", zNew, 0);
    drive(enc(6'b011010, 1'b1, 7'h11), 8'h00, 8'hFF, 1'b0); // R5 skip on zero
    expOut("R5", 8'h00, 1, 1, 0, 0, 0, 1);
    drive(enc(6'b011110, 1'b1, 7'h11), 8'h00, 8'h02, 1'b0);
    expOut("R5", 8'h01, 1, 1, 0, 0, 0, 0);
    drive(enc(6'b011110, 1'b0, 7'h11), 8'h00, 8'h01, 1'b0);
    expOut("R5", 8'h00, 0, 1, 0, 0, 0, 1);
  endtask

  task automatic testLogic();
    drive(enc(6'b010010, 1'b0, 7'h12), 8'hF0, 8'h0F, 1'b0); // R6
    expOut("R6", 8'h00, 0, 1, 0, 0, 1, 0); chk("R6", "Z", zNew, 1);
    drive(enc(6'b010011, 1'b1, 7'h12), 8'hF0, 8'h0F, 1'b0);
    expOut("R6", 8'hFF, 1, 1, 0, 0, 1, 0); chk("R6", "Z", zNew, 0);
    drive(enc(6'b010100, 1'b1, 7'h12), 8'hAA, 8'hAA, 1'b0);
    expOut("R6", 8'h00, 1, 1, 0, 0, 1, 0);
    drive(enc(6'b011111, 1'b0, 7'h12), 8'h00, 8'h5A, 1'b0);
    expOut("R6", 8'hA5, 0, 1, 0, 0, 1, 0);
    drive(enc(6'b011000, 1'b0, 7'h12), 8'h77, 8'h00, 1'b0);
    expOut("R6", 8'h00, 0, 1, 0, 0, 1, 0); chk("R6", "Z", zNew, 1);
    drive(enc(6'b010111, 1'b1, 7'h12), 8'h00, 8'h12, 1'b1); // R7
    expOut("R7", 8'h21, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic testRotate();
    drive(enc(6'b010110, 1'b1, 7'h13), 8'h00, 8'h81, 1'b0); // R8 right
    expOut("R8", 8'h40, 1, 1, 1, 0, 0, 0); chk("R8", "C", cNew, 1);
    drive(enc(6'b010110, 1'b0, 7'h13), 8'h00, 8'h02, 1'b1);
    expOut("R8", 8'h81, 0, 1, 1, 0, 0, 0); chk("R8", "C", cNew, 0);
    drive(enc(6'b010101, 1'b1, 7'h13), 8'h00, 8'h81, 1'b1); // R8 left
    expOut("R8", 8'h03, 1, 1, 1, 0, 0, 0); chk("R8", "C", cNew, 1);
    drive(enc(6'b010101, 1'b1, 7'h13), 8'h00, 8'h40, 1'b0);
    expOut("R8", 8'h80, 1, 1, 1, 0, 0, 0); chk("R8", "C", cNew, 0);
  endtask

  task automatic testBits();
    drive(encBit(2'b00, 3'd3, 7'h14), 8'h00, 8'hFF, 1'b0); // R9 clear
    expOut("R9", 8'hF7, 1, 1, 0, 0, 0, 0);
    drive(encBit(2'b10, 3'd7, 7'h14), 8'h00, 8'h00, 1'b0); // R9 set
    expOut("R9", 8'h80, 1, 1, 0, 0, 0, 0);
    drive(encBit(2'b01, 3'd2, 7'h14), 8'h00, 8'hFB, 1'b0); // R10 test clear
    expOut("R10", 8'h00, 1, 0, 0, 0, 0, 1);
    drive(encBit(2'b11, 3'd2, 7'h14), 8'h00, 8'hFB, 1'b0); // R10 test set
    expOut("R10", 8'h00, 1, 0, 0, 0, 0, 0);
    drive(encBit(2'b11, 3'd0, 7'h14), 8'h00, 8'h01, 1'b0);
    expOut("R10", 8'h00, 1, 0, 0, 0, 0, 1);
  endtask

  task automatic testLiteral();
    drive({6'b111010, 8'h5C}, 8'h00, 8'hEE, 1'b0); // R11 load
    expOut("R11", 8'h5C, 0, 1, 0, 0, 0, 0);
    drive({6'b110100, 8'h0F}, 8'hF0, 8'hFF, 1'b0);
    expOut("R11", 8'h00, 0, 1, 0, 0, 1, 0); chk("R11", "Z", zNew, 1);
    drive({6'b110101, 8'h0F}, 8'h30, 8'h00, 1'b0);
    expOut("R11", 8'h3F, 0, 1, 0, 0, 1, 0);
    drive({6'b110110, 8'hFF}, 8'h0F, 8'h00, 1'b0);
    expOut("R11", 8'hF0, 0, 1, 0, 0, 1, 0);
  endtask

  task automatic testClearMove();
    drive(enc(6'b010001, 1'b0, 7'h15), 8'h44, 8'h99, 1'b0); // R12 clear reg
    expOut("R12", 8'h00, 1, 1, 0, 0, 1, 0); chk("R12", "Z", zNew, 1);
    drive(enc(6'b010000, 1'b1, 7'h00), 8'h44, 8'h99, 1'b0); // R12 clear W
    expOut("R12", 8'h00, 0, 1, 0, 0, 1, 0); chk("R12", "Z", zNew, 1);
    drive(enc(6'b010001, 1'b1, 7'h15), 8'h9E, 8'h00, 1'b0); // R12 store W
    expOut("R12", 8'h9E, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic testNonAlu();
    logic [13:0] words [5] = '{14'h1003, 14'h2A55, 14'h3123, 14'h3234, 14'h3CFF};
    foreach (words[k]) begin
      drive(words[k], 8'h00, 8'h00, 1'b1); // R13
      chk("R13", "nonAlu", nonAlu, 1);
      chk("R13", "writeEn", writeEn, 0);
      chk("R13", "skipReq", skipReq, 0);
      chk("R13", "flagEn", {cWe, hcWe, zWe}, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    testIdle();
    testAdd();
    testSub();
    testIncDec();
    testLogic();
    testRotate();
    testBits();
    testLiteral();
    testClearMove();
    testNonAlu();
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule